// File: doc/BRIEF.md
# DMX-512 Packet Transmitter

This block sends DMX-512 lighting packets on one serial line, over and over, for as long as it is enabled. Every packet opens with a long low line condition (the break), then a short high interval (the mark after break). After that it sends a start-code byte and N level bytes. Each byte goes out as a 250 kbaud character with one start bit and two stop bits. The level bytes live in a small internal memory. A host fills that memory through a write port that clamps its data, and can read it back through a read port.

The configuration is taken from live inputs: the number of level slots, the start code that is loaded at reset, and the packet repeat period in tenths of a millisecond. The period is clamped to 10000 units and is timed from the start of one break to the start of the next. A transmit-enable output switches an external RS-485 driver. When that output comes on, the line stays idle high for one mark-after-break interval before the first break. All durations are derived from the `CLK_HZ` parameter.

Top module: `dmx_packet_tx`

## Requirements
- R1: After reset, `tx_line` is 1, `tx_en` is 0, slot 0 holds the `start_code` value present during reset, and every other slot holds 0.
- R2: When `enable` rises, `tx_en` goes to 1, and the first break begins exactly MAB_US microseconds of clock cycles later. One clock after `enable` falls, `tx_line` is 1 and `tx_en` is 0, even in the middle of a packet.
- R3: The break holds `tx_line` at 0 for BREAK_US (92) microseconds. The mark after break that follows holds it at 1 for MAB_US (12) microseconds.
- R4: Each character is one 0 start bit, then eight data bits with the least significant bit first, then two 1 stop bits. Every bit lasts CLK_HZ/250000 cycles. Within a packet, characters follow one another with no gap.
- R5: A packet carries slot 0 (the start code) and then slots 1 to N in order. N is `slot_count` clamped to the range 1 to 512, and it is taken at the start of each break.
- R6: When the packet fits in the period, consecutive breaks start `period_units` × CLK_HZ/10000 cycles apart.
- R7: With `period_units` equal to 0, the next break starts in the cycle right after the last stop bit ends.
- R8: When the packet is longer than the period, the next break starts right after the last stop bit. The period is then measured again from that break.
- R9: A write with `wr_addr` ≤ N updates that slot. A write with `wr_addr` > N changes no slot.
- R10: Write data is a signed value. Negative values are stored as 0, values above 255 are stored as 255, and other values are stored unchanged.
- R11: `rd_data` shows slot `rd_addr` when `rd_addr` ≤ N, and 0 otherwise.
- R12: Each slot byte is read once, when its character begins. A write during that character affects only later packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency CLK_HZ |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run packet transmission |
| slot_count | input | AW | Requested level-slot count N (clamped 1..512) |
| start_code | input | 8 | Value loaded into slot 0 at reset |
| period_units | input | PERIOD_W | Break-to-break period in 0.1 ms units (0 = back to back) |
| wr_en | input | 1 | Slot write strobe |
| wr_addr | input | AW | Slot to write (0 = start code) |
| wr_data | input | DIN_W | Signed value to write, clamped to 0..255 |
| rd_addr | input | AW | Slot to read |
| rd_data | output | 8 | Slot contents, or 0 for an invalid slot |
| tx_line | output | 1 | Serial data line, idles high |
| tx_en | output | 1 | Line driver enable |

## Verification
The bench decodes the line waveform independently. It finds each break by its length and times the break, the mark after break, every character edge and the gap from one break to the next, all in exact cycles. The corner cases it targets are these. A period shorter than the packet would give a truncated packet or a late break if the overrun rule were wrong. A zero period would leave an idle gap if back-to-back mode were broken. A slot count of 0 or above 512 would send an empty or oversized packet if the clamp were missing. A write landing mid-character would corrupt that character if bytes were not captured at the start bit. Out-of-range writes and out-of-range data would overwrite memory or wrap modulo 256 if the checks were wrong. A mid-packet disable would leave the driver on or the line low if shutdown were wrong.

// File: rtl/dmx_tx_pkg.sv
package dmx_tx_pkg;

   // line sequencer states
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_BREAK,
      ST_MAB,
      ST_CHAR,
      ST_GAP
   } tx_state_e;

   // start + 8 data + 2 stop
   localparam int FRAME_BITS = 11;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dmx_slot_store.sv
module dmx_slot_store #(
   parameter int MAX_SLOTS = 512,
   parameter int AW        = 10,
   parameter int DIN_W     = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [7:0]              init_code,
   input  logic [AW-1:0]           last_slot,
   input  logic                    wr_en,
   input  logic [AW-1:0]           wr_addr,
   input  logic signed [DIN_W-1:0] wr_data,
   input  logic [AW-1:0]           rd_addr,
   output logic [7:0]              rd_data,
   input  logic [AW-1:0]           fetch_addr,
   output logic [7:0]              fetch_data
);

   localparam logic signed [DIN_W-1:0] BYTE_TOP = DIN_W'(255);
   localparam logic [AW-1:0]           TOP_ADDR = AW'(MAX_SLOTS);

   logic [7:0] mem_q [MAX_SLOTS+1];
   logic [7:0] wr_byte;
   logic       wr_ok;

   // saturate the signed write value into one byte
   always_comb begin
      if (wr_data[DIN_W-1])         wr_byte = 8'h00;
      else if (wr_data > BYTE_TOP)  wr_byte = 8'hFF;
      else                          wr_byte = wr_data[7:0];
   end

   assign wr_ok = wr_en && (wr_addr <= last_slot);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 1; i <= MAX_SLOTS; i++) mem_q[i] <= 8'h00;
         mem_q[0] <= init_code;
      end else if (wr_ok) begin
         mem_q[wr_addr] <= wr_byte;
      end
   end

   assign rd_data    = (rd_addr <= last_slot) ? mem_q[rd_addr] : 8'h00;
   assign fetch_data = (fetch_addr <= TOP_ADDR) ? mem_q[fetch_addr] : 8'h00;

   // R9: a write above the slot count leaves the addressed byte alone
   a_r9_ignore_above: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr > last_slot && wr_addr <= TOP_ADDR)
      |=> mem_q[$past(wr_addr)] == $past(mem_q[wr_addr]));

   // R10: oversized values land as 255
   a_r10_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr <= last_slot && wr_data > BYTE_TOP)
      |=> mem_q[$past(wr_addr)] == 8'hFF);

endmodule

// File: rtl/dmx_period_timer.sv
module dmx_period_timer #(
   parameter int CNT_W = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic             due
);

   logic [CNT_W-1:0] cnt_q;

   // cycles elapsed since the current break began, saturating
   always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= '1;
      else if (restart)          cnt_q <= '0;
      else if (cnt_q != '1)      cnt_q <= cnt_q + CNT_W'(1);
   end

   assign due = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, limit};

   // R8: once the period has run out it stays out until the next break
   a_r8_due_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (due && !restart && $stable(limit)) |=> due);

endmodule

// File: rtl/dmx_frame_engine.sv
module dmx_frame_engine
   import dmx_tx_pkg::*;
#(
   parameter int CLK_HZ   = 50_000_000,
   parameter int BAUD     = 250_000,
   parameter int BREAK_US = 92,
   parameter int MAB_US   = 12,
   parameter int AW       = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic [AW-1:0] last_slot,
   input  logic          period_zero,
   input  logic          period_due,
   input  logic [7:0]    fetch_data,
   output logic [AW-1:0] fetch_addr,
   output logic          restart,
   output logic          line,
   output logic          active
);

   localparam int US_CYC    = CLK_HZ / 1_000_000;
   localparam int BREAK_CYC = US_CYC * BREAK_US;
   localparam int MAB_CYC   = US_CYC * MAB_US;
   localparam int BIT_CYC   = CLK_HZ / BAUD;
   localparam int TW        = $clog2(imax(imax(BREAK_CYC, MAB_CYC), BIT_CYC) + 1);
   localparam logic [TW-1:0] T_BREAK = TW'(BREAK_CYC - 1);
   localparam logic [TW-1:0] T_MAB   = TW'(MAB_CYC - 1);
   localparam logic [TW-1:0] T_BIT   = TW'(BIT_CYC - 1);
   localparam logic [3:0]    LAST_BIT = 4'(FRAME_BITS - 1);

   tx_state_e                state_q, st_d;
   logic [TW-1:0]            tmr_q, tmr_d;
   logic [3:0]               bit_q, bit_d;
   logic [FRAME_BITS-1:0]    sh_q, sh_d;
   logic [AW-1:0]            slot_q, slot_d, last_q, last_d;
   logic                     line_q, line_d, active_q;
   logic                     tick, brk_go;

   assign tick       = (tmr_q == '0);
   assign fetch_addr = (state_q == ST_MAB) ? '0 : slot_q + AW'(1);

   always_comb begin
      st_d   = state_q;
      tmr_d  = tick ? tmr_q : tmr_q - TW'(1);
      bit_d  = bit_q;
      sh_d   = sh_q;
      slot_d = slot_q;
      last_d = last_q;
      brk_go = 1'b0;
      if (!enable) begin
         st_d = ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               st_d  = ST_LEAD;
               tmr_d = T_MAB;
            end
            ST_LEAD:  brk_go = tick;
            ST_BREAK: if (tick) begin
               st_d  = ST_MAB;
               tmr_d = T_MAB;
            end
            ST_MAB: if (tick) begin
               st_d  = ST_CHAR;
               tmr_d = T_BIT;
               bit_d = '0;
               sh_d  = {2'b11, fetch_data, 1'b0};
            end
            ST_CHAR: if (tick) begin
               if (bit_q != LAST_BIT) begin
                  sh_d  = {1'b1, sh_q[FRAME_BITS-1:1]};
                  bit_d = bit_q + 4'd1;
                  tmr_d = T_BIT;
               end else if (slot_q != last_q) begin
                  slot_d = slot_q + AW'(1);
                  sh_d   = {2'b11, fetch_data, 1'b0};
                  bit_d  = '0;
                  tmr_d  = T_BIT;
               end else if (period_zero || period_due) begin
                  brk_go = 1'b1;
               end else begin
                  st_d = ST_GAP;
               end
            end
            ST_GAP:   brk_go = period_due;
            default:  st_d = ST_IDLE;
         endcase
      end
      if (brk_go) begin
         st_d   = ST_BREAK;
         tmr_d  = T_BREAK;
         slot_d = '0;
         last_d = last_slot;
      end
      case (st_d)
         ST_BREAK: line_d = 1'b0;
         ST_CHAR:  line_d = sh_d[0];
         default:  line_d = 1'b1;
      endcase
   end

   assign restart = brk_go;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         tmr_q    <= '0;
         bit_q    <= '0;
         sh_q     <= '1;
         slot_q   <= '0;
         last_q   <= AW'(1);
         line_q   <= 1'b1;
         active_q <= 1'b0;
      end else begin
         state_q  <= st_d;
         tmr_q    <= tmr_d;
         bit_q    <= bit_d;
         sh_q     <= sh_d;
         slot_q   <= slot_d;
         last_q   <= last_d;
         line_q   <= line_d;
         active_q <= (st_d != ST_IDLE);
      end
   end

   assign line   = line_q;
   assign active = active_q;

   // R3: the line is low throughout the break
   a_r3_break_low: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BREAK) |-> !line_q);

   // R3: the break does not end before its timer does
   a_r3_break_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BREAK && !tick && enable) |=> (state_q == ST_BREAK));

   // R4: a bit level holds until its bit time expires
   a_r4_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CHAR && !tick && enable) |=> $stable(line_q));

   // R7: with no period, the last stop bit leads straight into a break
   a_r7_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CHAR && tick && bit_q == LAST_BIT && slot_q == last_q
       && period_zero && enable) |=> (state_q == ST_BREAK));

endmodule

// File: rtl/dmx_packet_tx.sv
module dmx_packet_tx
   import dmx_tx_pkg::*;
#(
   parameter int CLK_HZ     = 50_000_000,
   parameter int BAUD       = 250_000,
   parameter int BREAK_US   = 92,
   parameter int MAB_US     = 12,
   parameter int MAX_SLOTS  = 512,
   parameter int PERIOD_MAX = 10_000,
   parameter int PERIOD_W   = 14,
   parameter int DIN_W      = 12,
   parameter bit USE_TXEN   = 1'b1,
   localparam int AW        = $clog2(MAX_SLOTS + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enable,
   input  logic [AW-1:0]           slot_count,
   input  logic [7:0]              start_code,
   input  logic [PERIOD_W-1:0]     period_units,
   input  logic                    wr_en,
   input  logic [AW-1:0]           wr_addr,
   input  logic signed [DIN_W-1:0] wr_data,
   input  logic [AW-1:0]           rd_addr,
   output logic [7:0]              rd_data,
   output logic                    tx_line,
   output logic                    tx_en
);

   localparam int UNIT_CYC = CLK_HZ / 10_000;
   localparam int CNT_W    = $clog2(PERIOD_MAX * UNIT_CYC + 2) + 1;

   initial begin
      assert (CLK_HZ % 1_000_000 == 0) else $fatal(1, "CLK_HZ must be whole MHz");
      assert (CLK_HZ % BAUD == 0 && CLK_HZ / BAUD >= 2) else $fatal(1, "bit time invalid");
      assert (MAB_US >= 1 && BREAK_US >= 1) else $fatal(1, "line intervals invalid");
      assert (DIN_W >= 9) else $fatal(1, "DIN_W must hold a sign and 255");
      assert (PERIOD_MAX < (1 << PERIOD_W)) else $fatal(1, "PERIOD_W too narrow");
   end

   logic [AW-1:0]       last_slot, fetch_addr;
   logic [PERIOD_W-1:0] units_c;
   logic [CNT_W-1:0]    per_cyc;
   logic [7:0]          fetch_data;
   logic                restart, due, eng_active;

   always_comb begin
      if (slot_count == '0)                   last_slot = AW'(1);
      else if (slot_count > AW'(MAX_SLOTS))   last_slot = AW'(MAX_SLOTS);
      else                                    last_slot = slot_count;
      if (period_units > PERIOD_W'(PERIOD_MAX)) units_c = PERIOD_W'(PERIOD_MAX);
      else                                      units_c = period_units;
   end

   assign per_cyc = CNT_W'(units_c) * CNT_W'(UNIT_CYC);

   dmx_slot_store #(.MAX_SLOTS(MAX_SLOTS), .AW(AW), .DIN_W(DIN_W)) u_store (
      .clk(clk), .rst_n(rst_n), .init_code(start_code), .last_slot(last_slot),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .fetch_addr(fetch_addr), .fetch_data(fetch_data));

   dmx_period_timer #(.CNT_W(CNT_W)) u_period (
      .clk(clk), .rst_n(rst_n), .restart(restart), .limit(per_cyc), .due(due));

   dmx_frame_engine #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .BREAK_US(BREAK_US),
                      .MAB_US(MAB_US), .AW(AW)) u_engine (
      .clk(clk), .rst_n(rst_n), .enable(enable), .last_slot(last_slot),
      .period_zero(units_c == '0), .period_due(due),
      .fetch_data(fetch_data), .fetch_addr(fetch_addr),
      .restart(restart), .line(tx_line), .active(eng_active));

   generate
      if (USE_TXEN) begin : g_txen
         assign tx_en = eng_active;
         // R1: whenever the driver is off the line sits at idle
         a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
            !tx_en |-> tx_line);
      end else begin : g_no_txen
         assign tx_en = 1'b0;
      end
   endgenerate

   // R2: dropping enable returns the outputs to idle on the next clock
   a_r2_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (tx_line && !tx_en));

endmodule

// File: tb/test_dmx_packet_tx.sv
module test_dmx_packet_tx;

   // 50 MHz bench clock; the design is told 5 MHz so every interval is
   // ten times shorter in cycles and the run stays brief
   localparam int CLK_HZ  = 5_000_000;
   localparam int BIT_C   = CLK_HZ / 250_000;          // 20
   localparam int CHAR_C  = 11 * BIT_C;                // 220
   localparam int BRK_C   = 92 * (CLK_HZ / 1_000_000); // 460
   localparam int MAB_C   = 12 * (CLK_HZ / 1_000_000); // 60
   localparam int UNIT_C  = CLK_HZ / 10_000;           // 500
   localparam int WD_CYC  = 150_000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              enable = 1'b0;
   logic [9:0]        slot_count = 10'd3;
   logic [7:0]        start_code = 8'h5A;
   logic [13:0]       period_units = '0;
   logic              wr_en = 1'b0;
   logic [9:0]        wr_addr = '0;
   logic signed [11:0] wr_data = '0;
   logic [9:0]        rd_addr = '0;
   logic [7:0]        rd_data;
   logic              tx_line, tx_en;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   logic [7:0] cap_b [0:7];
   int cap_mab, cap_b2b, cap_next;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dmx_packet_tx #(.CLK_HZ(CLK_HZ)) i_dmx_packet_tx (
      .clk(clk), .rst_n(rst_n), .enable(enable), .slot_count(slot_count),
      .start_code(start_code), .period_units(period_units),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .tx_line(tx_line), .tx_en(tx_en));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int v);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = addr[9:0]; wr_data = v[11:0];
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int addr, output int v);
      @(negedge clk);
      rd_addr = addr[9:0];
      @(negedge clk);
      v = int'(rd_data);
   endtask

   task automatic wait_level(input logic lv, output int t);
      while (tx_line !== lv) @(negedge clk);
      t = cyc;
   endtask

   // a low run longer than any character marks a break
   task automatic find_break(output int tb, output int tm);
      int a, b;
      wait_level(1'b1, a);
      forever begin
         wait_level(1'b0, a);
         wait_level(1'b1, b);
         if (b - a > CHAR_C) begin
            tb = a; tm = b;
            break;
         end
      end
   endtask

   task automatic capture_rest(input int tb, input int tm, input int nbytes);
      int ts, tprev, tn;
      logic [7:0] v;
      tprev = 0;
      v = '0;
      for (int i = 0; i < nbytes; i++) begin
         wait_level(1'b0, ts);
         if (i == 0) cap_mab = ts - tm;
         else check("R4 character spacing", ts - tprev, CHAR_C);
         repeat (BIT_C / 2) @(negedge clk);
         check("R4 start bit level", int'(tx_line), 0);
         for (int b = 0; b < 8; b++) begin
            repeat (BIT_C) @(negedge clk);
            v[b] = tx_line;
         end
         for (int s = 0; s < 2; s++) begin
            repeat (BIT_C) @(negedge clk);
            check("R4 stop bit level", int'(tx_line), 1);
         end
         cap_b[i] = v;
         tprev = ts;
      end
      wait_level(1'b0, tn);
      cap_next = tn;
      cap_b2b = tn - tb;
   endtask

   task automatic t_reset();
      int v;
      check("R1 line idle after reset", int'(tx_line), 1);
      check("R1 tx_en low after reset", int'(tx_en), 0);
      rd(0, v); check("R1 slot 0 holds start code", v, 8'h5A);
      rd(2, v); check("R1 slot 2 cleared", v, 0);
   endtask

   task automatic t_slot_port();
      int v;
      wr(1, 8'hA5);
      wr(2, -7);
      wr(3, 300);
      wr(4, 8'h44);                 // above N=3
      rd(1, v); check("R9 slot 1 written", v, 8'hA5);
      rd(2, v); check("R10 negative clamps to 0", v, 0);
      rd(3, v); check("R10 large clamps to 255", v, 255);
      rd(4, v); check("R11 read above N gives 0", v, 0);
      rd(600, v); check("R11 read beyond memory gives 0", v, 0);
      slot_count = 10'd4;
      rd(4, v); check("R9 write above N was ignored", v, 0);
      slot_count = 10'd1000;        // clamps to 512
      wr(512, 8'h77);
      wr(513, 8'h66);
      rd(512, v); check("R5 count clamps to 512", v, 8'h77);
      rd(513, v); check("R11 slot 513 invalid", v, 0);
      slot_count = 10'd3;
   endtask

   task automatic t_first_packet();
      int t_en, tb, tm;
      period_units = '0;
      @(negedge clk);
      enable = 1'b1;
      while (tx_en !== 1'b1) @(negedge clk);
      t_en = cyc;
      wait_level(1'b0, tb);
      check("R2 lead-in before first break", tb - t_en, MAB_C);
      wait_level(1'b1, tm);
      check("R3 break length", tm - tb, BRK_C);
      capture_rest(tb, tm, 4);
      check("R3 mark after break length", cap_mab, MAB_C);
      check("R5 byte 0 start code", int'(cap_b[0]), 8'h5A);
      check("R5 byte 1", int'(cap_b[1]), 8'hA5);
      check("R5 byte 2", int'(cap_b[2]), 8'h00);
      check("R5 byte 3", int'(cap_b[3]), 8'hFF);
      check("R7 zero period back to back", cap_b2b, BRK_C + MAB_C + 4 * CHAR_C);
   endtask

   task automatic t_period();
      int tb, tm;
      period_units = 14'd4;
      find_break(tb, tm);
      capture_rest(tb, tm, 4);
      check("R6 break to break period", cap_b2b, 4 * UNIT_C);
   endtask

   task automatic t_overrun();
      int tb, tm;
      period_units = 14'd2;
      find_break(tb, tm);
      capture_rest(tb, tm, 4);
      check("R8 overrun breaks after stop bit", cap_b2b, BRK_C + MAB_C + 4 * CHAR_C);
      tb = cap_next;
      wait_level(1'b1, tm);
      capture_rest(tb, tm, 4);
      check("R8 period re-referenced", cap_b2b, BRK_C + MAB_C + 4 * CHAR_C);
   endtask

   task automatic t_single_slot();
      int tb, tm;
      period_units = '0;
      slot_count = 10'd0;           // clamps to 1
      find_break(tb, tm);
      capture_rest(tb, tm, 2);
      check("R5 minimum one slot byte 1", int'(cap_b[1]), 8'hA5);
      check("R5 minimum packet length", cap_b2b, BRK_C + MAB_C + 2 * CHAR_C);
   endtask

   task automatic t_coherent();
      int tb, tm;
      slot_count = 10'd1;
      wr(1, 8'h11);
      find_break(tb, tm);
      fork
         capture_rest(tb, tm, 2);
         begin
            repeat (MAB_C + CHAR_C + 60) @(negedge clk);
            wr(1, 8'hEE);
         end
      join
      check("R12 byte kept during character", int'(cap_b[1]), 8'h11);
      tb = cap_next;
      wait_level(1'b1, tm);
      capture_rest(tb, tm, 2);
      check("R12 new value next packet", int'(cap_b[1]), 8'hEE);
   endtask

   task automatic t_disable();
      int tb, tm;
      slot_count = 10'd3;
      find_break(tb, tm);
      repeat (MAB_C + 10) @(negedge clk);  // inside the first start bit
      enable = 1'b0;
      @(negedge clk);
      check("R2 line high after disable", int'(tx_line), 1);
      check("R2 tx_en low after disable", int'(tx_en), 0);
      repeat (3 * BRK_C) @(negedge clk);
      check("R2 stays idle", int'(tx_line), 1);
   endtask

   initial begin
      repeat (WD_CYC) @(posedge clk);
      errors++;
      $display("FAIL watchdog (R2-driven sequence hung) actual=%0d expected<%0d", cyc, WD_CYC);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_slot_port();
      t_first_packet();
      t_period();
      t_overrun();
      t_single_slot();
      t_coherent();
      t_disable();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule